// File: doc/BRIEF.md
# Configurable Interrupt Request Generator

This block gathers single-cycle event strobes from up to `NUM_EVT` sources into a sticky pending register and turns them into one interrupt pin toward a host CPU. Software sees four registers over a plain single-cycle register port: a control register, the pending-status register, a per-source enable mask and a timing register. A pending bit that is also enabled makes the interrupt request. A global gate in the control register can hold the pin inactive.

The pin has two shapes. In level shape it stays active while any enabled bit is pending. In pulse shape it gives a pulse of programmable width. After the pulse comes an optional quiet window, measured in blocks of 256 clocks, in which new events are latched but raise no pulse. A single pulse then covers everything that collected in the window. Either polarity can be chosen. The block has no data stream, so it has no valid/ready interface and no back-pressure. Every pin is plain control or status.

Top module: `irqgen_top`

## Requirements
- R1: After reset the control register reads 0 (gate off, level shape, active low), status and enable read 0, the timing register reads 0x00000021, and `irq_out` is high.
- R2: A 1 on `evt_strobe[i]` sets status bit i, which stays set; status is read at address 1.
- R3: A write to address 1 clears each status bit whose data bit is 1 and leaves a bit unchanged where the data bit is 0.
- R4: When a strobe and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R5: With control bit 0 (global gate) clear, `irq_out` stays at its inactive level in both shapes.
- R6: Level shape (control bit 1 = 0): the request is active exactly while the gate is set and status AND enable is non-zero. It drops in the first cycle after the write that clears the last enabled bit.
- R7: Control bit 2 selects polarity: 1 drives the pin high when active, 0 drives it low when active.
- R8: Pulse shape (control bit 1 = 1): a pulse lasts timing bits 15:0 clocks, and a value of 0 gives one clock. A pulse starts one cycle after the timer is idle and an armed, enabled pending bit is seen.
- R9: After each pulse, no new pulse starts for timing bits 31:24 times 256 clocks. Events in that window are latched, and a single pulse follows when the window ends.
- R10: After a pulse, a further pulse needs re-arming first: either status AND enable becomes zero, or a strobe arrives on an enabled source. Events in the pulse-start cycle do not re-arm.
- R11: The enable register at address 2 masks sources: a pending bit whose enable bit is 0 raises no request.
- R12: Reads return control in bits 2:0 (address 0), the timing register with bits 23:16 as zero (address 3), and status and enable in their low `NUM_EVT` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_strobe | input | NUM_EVT | Event strobes, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 status, 2 enable, 3 timing) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Interrupt request pin |

## Verification
Two things can fall in the same cycle. First, a source strobe and a software clear of the same status bit. The bench drives both in one cycle and expects the bit to stay set. It also clears one bit while a different bit is strobed, and expects exactly the strobed bit to survive. Second, in pulse shape, a new event can land while the quiet window is running. The bench strobes two sources mid-window, expects the pin to stay silent, and then expects exactly one pulse of the programmed width when the window ends. A behavioural model in the bench predicts the pin on every clock.

// File: rtl/irqgen_pkg.sv
package irqgen_pkg;
  typedef enum logic [1:0] {
    ES_IDLE  = 2'd0,
    ES_PULSE = 2'd1,
    ES_GAP   = 2'd2
  } edge_st_e;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_ENAB = 2'd2;
  localparam logic [1:0] ADDR_TIME = 2'd3;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned PW_W    = 16;
  localparam int unsigned GAP_W   = 8;
  localparam int unsigned GAP_LSB = 24;
endpackage

// File: rtl/irqgen_status.sv
module irqgen_status #(
  parameter int unsigned NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt,
  input  logic [NUM_EVT-1:0] clr_mask,
  output logic [NUM_EVT-1:0] status
);
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          status[i] <= 1'b0;
      else if (evt[i])     status[i] <= 1'b1;
      else if (clr_mask[i]) status[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqgen_edge.sv
module irqgen_edge
  import irqgen_pkg::*;
#(
  parameter int unsigned PW_BITS   = 16,
  parameter int unsigned GAP_BITS  = 8,
  parameter int unsigned GAP_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                gate,
  input  logic                pend_any,
  input  logic                new_evt,
  input  logic [PW_BITS-1:0]  pw,
  input  logic [GAP_BITS-1:0] gap,
  output logic                pulse_on
);
  localparam int unsigned GL_W  = GAP_BITS + GAP_SHIFT;
  localparam int unsigned CNT_W = (PW_BITS > GL_W) ? PW_BITS : GL_W;

  edge_st_e          st;
  logic [CNT_W-1:0]  cnt;
  logic              armed;
  logic              fire;
  logic [CNT_W-1:0]  pw_load;
  logic [CNT_W-1:0]  gap_load;

  assign fire     = run && gate && (st == ES_IDLE) && pend_any && armed;
  assign pw_load  = (pw == '0) ? CNT_W'(1) : CNT_W'(pw);
  assign gap_load = CNT_W'({gap, {GAP_SHIFT{1'b0}}});
  assign pulse_on = (st == ES_PULSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
    end else if (fire) begin
      armed <= 1'b0;
    end else if (new_evt || !pend_any) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ES_IDLE;
      cnt <= '0;
    end else if (!run) begin
      st  <= ES_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ES_IDLE: begin
          if (fire) begin
            st  <= ES_PULSE;
            cnt <= pw_load;
          end
        end
        ES_PULSE: begin
          if (cnt <= CNT_W'(1)) begin
            if (gap == '0) begin
              st <= ES_IDLE;
            end else begin
              st  <= ES_GAP;
              cnt <= gap_load;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ES_GAP: begin
          if (cnt <= CNT_W'(1)) st <= ES_IDLE;
          else                  cnt <= cnt - CNT_W'(1);
        end
        default: st <= ES_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/irqgen_top.sv
module irqgen_top
  import irqgen_pkg::*;
#(
  parameter int unsigned NUM_EVT   = 8,
  parameter logic [15:0] PW_RST    = 16'h0021,
  parameter int unsigned GAP_SHIFT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_strobe,
  input  logic               reg_wr,
  input  logic [1:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               irq_out
);
  logic [2:0]         ctrl_q;
  logic [NUM_EVT-1:0] en_q;
  logic [PW_W-1:0]    pw_q;
  logic [GAP_W-1:0]   gap_q;
  logic [NUM_EVT-1:0] status_q;
  logic [NUM_EVT-1:0] clr_mask;
  logic               pulse_on;
  logic               gate, run_edge, pol, pend_any, new_evt, act;
  logic               wdata_unused;

  assign gate     = ctrl_q[0];
  assign run_edge = ctrl_q[1];
  assign pol      = ctrl_q[2];

  assign clr_mask = (reg_wr && reg_addr == ADDR_STAT) ? reg_wdata[NUM_EVT-1:0] : '0;
  assign pend_any = |(status_q & en_q);
  assign new_evt  = |(evt_strobe & en_q);
  assign wdata_unused = ^reg_wdata[GAP_LSB-1:PW_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= '0;
      pw_q   <= PW_RST;
      gap_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADDR_CTRL: ctrl_q <= reg_wdata[2:0];
        ADDR_ENAB: en_q   <= reg_wdata[NUM_EVT-1:0];
        ADDR_TIME: begin
          pw_q  <= reg_wdata[PW_W-1:0];
          gap_q <= reg_wdata[GAP_LSB +: GAP_W];
        end
        default: ;
      endcase
    end
  end

  irqgen_status #(.NUM_EVT(NUM_EVT)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_strobe),
    .clr_mask (clr_mask),
    .status   (status_q)
  );

  irqgen_edge #(
    .PW_BITS   (PW_W),
    .GAP_BITS  (GAP_W),
    .GAP_SHIFT (GAP_SHIFT)
  ) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_edge),
    .gate     (gate),
    .pend_any (pend_any),
    .new_evt  (new_evt),
    .pw       (pw_q),
    .gap      (gap_q),
    .pulse_on (pulse_on)
  );

  assign act     = gate && (run_edge ? pulse_on : pend_any);
  assign irq_out = pol ? act : !act;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: reg_rdata[2:0]         = ctrl_q;
      ADDR_STAT: reg_rdata[NUM_EVT-1:0] = status_q;
      ADDR_ENAB: reg_rdata[NUM_EVT-1:0] = en_q;
      default: begin
        reg_rdata[PW_W-1:0]       = pw_q;
        reg_rdata[GAP_LSB +: GAP_W] = gap_q;
      end
    endcase
  end
endmodule

// File: rtl/irqgen_chk.sv
module irqgen_chk #(
  parameter int unsigned NUM_EVT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq_out,
  input logic [2:0]         ctrl,
  input logic [NUM_EVT-1:0] status,
  input logic [NUM_EVT-1:0] en,
  input logic [NUM_EVT-1:0] evt,
  input logic [NUM_EVT-1:0] clr
);
  logic act;
  assign act = ctrl[2] ? irq_out : !irq_out;

  AST_GATE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !act); // R5

  AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !ctrl[1]) |-> (act == ((status & en) != '0))); // R6

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status) & ~$past(clr)) & ~status) == '0)); // R3

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> (($past(evt) & ~status) == '0)); // R4

  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[1] && $rose(act) && $stable(ctrl)) |-> ($past(status & en) != '0)); // R8
endmodule

bind irqgen_top irqgen_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .irq_out (irq_out),
  .ctrl    (ctrl_q),
  .status  (status_q),
  .en      (en_q),
  .evt     (evt_strobe),
  .clr     (clr_mask)
);

// File: tb/tb_irqgen_top.sv
`timescale 1ns/1ps
module tb_irqgen_top;
  localparam int NE = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NE-1:0] evt_strobe = '0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out;

  always #2.5 clk = ~clk;

  irqgen_top #(.NUM_EVT(NE)) dut (
    .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_out(irq_out)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string phase = "R1";
  int    cyc = 0;

  // behavioural reference state
  int m_ctrl, m_stat, m_en, m_pw, m_gap, m_st, m_cnt;
  bit m_armed;

  task automatic chk(input string tag, input logic [31:0] actv, input logic [31:0] expv);
    n_chk++;
    if (actv !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, actv, expv);
    end
  endtask

  function automatic bit model_pin();
    bit gate, act;
    gate = (m_ctrl & 1) != 0;
    if ((m_ctrl & 2) != 0) act = gate && (m_st == 1);
    else                   act = gate && ((m_stat & m_en) != 0);
    return ((m_ctrl & 4) != 0) ? act : !act;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_stat = 0; m_en = 0; m_pw = 'h21; m_gap = 0;
      m_st = 0; m_cnt = 0; m_armed = 1;
    end else begin
      int pend, clr, w;
      bit run, start, newev;
      pend  = m_stat & m_en;
      run   = (m_ctrl & 2) != 0;
      newev = (int'(evt_strobe) & m_en) != 0;
      start = run && ((m_ctrl & 1) != 0) && m_st == 0 && pend != 0 && m_armed;
      if (start) m_armed = 0;
      else if (newev || pend == 0) m_armed = 1;
      if (!run) begin
        m_st = 0; m_cnt = 0;
      end else if (m_st == 0) begin
        if (start) begin m_st = 1; m_cnt = (m_pw == 0) ? 1 : m_pw; end
      end else if (m_st == 1) begin
        if (m_cnt <= 1) begin
          if (m_gap == 0) m_st = 0;
          else begin m_st = 2; m_cnt = m_gap * 256; end
        end else m_cnt--;
      end else begin
        if (m_cnt <= 1) m_st = 0; else m_cnt--;
      end
      w   = int'(reg_wdata);
      clr = (reg_wr && reg_addr == 2'd1) ? (w & 'hFF) : 0;
      m_stat = ((m_stat & ~clr) | int'(evt_strobe)) & 'hFF;
      if (reg_wr) begin
        case (reg_addr)
          2'd0: m_ctrl = w & 7;
          2'd2: m_en   = w & 'hFF;
          2'd3: begin m_pw = w & 'hFFFF; m_gap = (w >> 24) & 'hFF; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) chk({phase, " pin vs model"}, {31'b0, irq_out}, {31'b0, model_pin()});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic strobe(input logic [NE-1:0] m);
    @(negedge clk); #1; evt_strobe = m;
    @(negedge clk); #1; evt_strobe = '0;
  endtask

  task automatic strobe_and_clear(input logic [NE-1:0] m, input logic [31:0] c);
    @(negedge clk); #1;
    evt_strobe = m; reg_wr = 1; reg_addr = 2'd1; reg_wdata = c;
    @(negedge clk); #1;
    evt_strobe = '0; reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); #1; reg_addr = a; #1;
    chk(tag, reg_rdata, e);
  endtask

  task automatic pin_is(input logic e, input string tag);
    @(negedge clk); #1;
    chk(tag, {31'b0, irq_out}, {31'b0, e});
  endtask

  task automatic count_low(input int n, input int e, input string tag);
    int c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq_out == 1'b0) c++;
    end
    chk(tag, c, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    phase = "R1";
    pin_is(1'b1, "R1 pin after reset");
    rd(2'd0, 32'h0, "R1 ctrl reset");
    rd(2'd1, 32'h0, "R1 status reset");
    rd(2'd2, 32'h0, "R1 enable reset");
    rd(2'd3, 32'h21, "R1 timing reset");

    phase = "R2";
    strobe(8'h08);
    rd(2'd1, 32'h08, "R2 status sticky");

    phase = "R5";
    wr(2'd2, 32'hFF);
    repeat (4) @(negedge clk);
    pin_is(1'b1, "R5 gate off level");

    phase = "R6";
    wr(2'd0, 32'h1);
    pin_is(1'b0, "R6 level active");
    phase = "R3";
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h08, "R3 zero write keeps");
    wr(2'd1, 32'h08);
    rd(2'd1, 32'h00, "R3 one write clears");
    pin_is(1'b1, "R6 drops after clear");

    phase = "R4";
    strobe(8'h04);
    strobe_and_clear(8'h04, 32'h04);
    rd(2'd1, 32'h04, "R4 same-cycle set wins");
    strobe_and_clear(8'h10, 32'h04);
    rd(2'd1, 32'h10, "R4 clear one set other");

    phase = "R7";
    wr(2'd0, 32'h5);
    pin_is(1'b1, "R7 active high");
    wr(2'd0, 32'h1);
    pin_is(1'b0, "R7 active low");

    phase = "R11";
    wr(2'd1, 32'hFF);
    wr(2'd2, 32'h0F);
    strobe(8'h40);
    repeat (2) @(negedge clk);
    pin_is(1'b1, "R11 masked source quiet");
    rd(2'd1, 32'h40, "R11 masked still latched");
    wr(2'd1, 32'h40);

    phase = "R12";
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'hFF00_FFFF, "R12 timing layout");
    wr(2'd0, 32'hFFFF_FFF8);
    rd(2'd0, 32'h0, "R12 ctrl width");
    rd(2'd2, 32'h0F, "R12 enable readback");

    phase = "R8";
    wr(2'd0, 32'h3);
    wr(2'd3, 32'h5);
    strobe(8'h01);
    count_low(12, 5, "R8 pulse width 5");

    phase = "R10";
    count_low(30, 0, "R10 no repeat while unarmed");
    strobe(8'h02);
    count_low(20, 5, "R10 new event rearms");
    wr(2'd1, 32'hFF);
    strobe(8'h01);
    count_low(20, 5, "R10 after clear");

    phase = "R8";
    wr(2'd3, 32'h0);
    wr(2'd1, 32'hFF);
    strobe(8'h04);
    count_low(10, 1, "R8 zero width gives one clock");

    phase = "R9";
    wr(2'd1, 32'hFF);
    wr(2'd3, 32'h0200_0004);
    strobe(8'h01);
    count_low(10, 4, "R9 first pulse");
    strobe(8'h02);
    strobe(8'h04);
    count_low(400, 0, "R9 silent in window");
    count_low(200, 4, "R9 one pulse after window");
    rd(2'd1, 32'h07, "R9 events latched in window");

    phase = "R5";
    wr(2'd1, 32'hFF);
    wr(2'd0, 32'h2);
    strobe(8'h08);
    count_low(50, 0, "R5 gate off edge");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule